// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Sequencer

This block drives an open-drain single-wire bus as the master. Software issues one of three commands: a bus reset with presence detection, a write-0 slot, or a write-1 slot. A write-1 slot also serves as a read slot. The block runs the whole time slot on its own, then clears the command bit and pulses `done`. The line is never driven high. The block pulls it low by raising `line_oe` and releases it by dropping `line_oe`. An external pull-up restores the high level, and the resolved level comes back on `line_in`.

All slot timing counts in 1 µs units. An integer prescaler derives these units from the system clock: `clk_div` gives the number of system clocks per microsecond. The time base is exact only when the system clock is an integer multiple of 1 MHz. Clocks slower than 10 MHz are not supported, so any divider value below 10 is raised to 10. The divider value is captured when a command starts. The level sampled in a read slot is kept in `rd_bit`. The outcome of the last reset is kept in `no_presence`. ROM search, CRC and device enumeration are left to software.

Top module: `ow_bus_master`

## Requirements
- R1: After synchronous reset, `line_oe`, `busy`, `done`, the three command bits, `no_presence` and `rd_bit` are all 0.
- R2: One time unit lasts exactly `clk_div` system clocks. Any `clk_div` value below 10, including 0, is treated as 10.
- R3: A bus reset pulls the line low for 480 units. The whole command, from the accepting clock edge to the clearing of `busy`, takes 960 units. `done` is then high for exactly one clock, in the cycle after `busy` falls.
- R4: `no_presence` is set to 1 when a bus reset starts. It is cleared if `line_in` is low at the sample point 70 units after the line is released. Otherwise it stays 1.
- R5: A write-0 slot pulls the line low for 100 units, and the slot lasts 117 units.
- R6: A write-1 slot pulls the line low for 5 units, and the slot lasts 117 units. `rd_bit` takes the level of `line_in` (0 = low, 1 = high) sampled 15 units after the slot starts.
- R7: `rd_bit` changes only in write-1 slots. Write-0 slots and bus resets leave it unchanged.
- R8: While `busy` is 1, command strobes are ignored: the running command keeps its timing and its status effects. At most one command bit is set at any time. Each bit reads 1 while its command runs and clears itself at the end.
- R9: When several strobes arrive in the same idle cycle, the bus reset wins over write-0, and write-0 wins over write-1.
- R10: A change of `clk_div` while a command runs has no effect on that command.
- R11: `line_oe` is 1 only while a command is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_div | input | DIV_W | System clocks per 1 µs unit (values below 10 read as 10) |
| cmd_reset | input | 1 | Strobe: start a bus reset with presence detection |
| cmd_wr0 | input | 1 | Strobe: start a write-0 slot |
| cmd_wr1 | input | 1 | Strobe: start a write-1 / read slot |
| busy | output | 1 | A command is running |
| done | output | 1 | One-clock pulse when a command completes |
| ctl_reset | output | 1 | Self-clearing command bit for the bus reset |
| ctl_wr0 | output | 1 | Self-clearing command bit for write-0 |
| ctl_wr1 | output | 1 | Self-clearing command bit for write-1 / read |
| no_presence | output | 1 | 1 = no device answered the last bus reset |
| rd_bit | output | 1 | Line level sampled in the last write-1 slot |
| line_oe | output | 1 | 1 pulls the bus low; 0 releases it |
| line_in | input | 1 | Resolved bus level |

## Verification
The bench times each slot shape in clock cycles. It counts the cycles with `line_oe` high and the cycles with `busy` high, which catches an off-by-one at the tick or the phase compare: one missing tick shortens a pulse by a whole `clk_div` cycles. A simple slave model answers with a presence pulse or holds the line low through the read sample point. A design that sampled at the wrong moment would report a phantom device or misread bits. Divider values 0 and 4 are run to expose a missing floor; without it the slot would shrink to a few clocks. The divider is changed in the middle of a slot to expose a prescaler that is not latched. A reset strobe is injected during a write-0 slot and all three strobes are raised at once; a design that lets a later command cut in, or orders the priority wrongly, would show a different pulse length or set `no_presence`. A read of 1 followed by a write-0 and a bus reset shows whether those commands wrongly overwrite `rd_bit`, since the master itself holds the line low at 15 units in both.

// File: rtl/ow_pkg.sv
package ow_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RST  = 2'd1,
    OP_WR0  = 2'd2,
    OP_WR1  = 2'd3
  } op_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;
  logic             wrap;

  always_comb begin
    div_eff = (div_in < FLOOR) ? FLOOR : div_in;
    wrap    = (cnt == div_q - 1'b1);
    tick    = run && wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= FLOOR;
      cnt   <= '0;
    end else if (load) begin
      div_q <= div_eff;
      cnt   <= '0;
    end else if (run) begin
      if (wrap) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end

  p_div_floor_r2: assert property (@(posedge clk) disable iff (rst)
    div_q >= FLOOR);

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt < div_q);

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  p_div_held_r10: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> $stable(div_q));

endmodule

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int   STAGES  = 2,
  parameter logic IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= IDLE_LV;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= IDLE_LV;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ow_slot_seq.sv
module ow_slot_seq
  import ow_pkg::*;
#(
  parameter int T_RST_LOW = 480,
  parameter int T_RST_REC = 480,
  parameter int T_PRES    = 70,
  parameter int T_W0_LOW  = 100,
  parameter int T_W1_LOW  = 5,
  parameter int T_RD_SMP  = 15,
  parameter int T_SLOT    = 117
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start_vld,
  input  op_e  start_op,
  input  logic line_s,
  output op_e  op,
  output logic oe,
  output logic done,
  output logic no_pres,
  output logic rd_bit
);
  localparam int RST_TOT = T_RST_LOW + T_RST_REC;
  localparam int MAX_T   = max2(RST_TOT, T_SLOT);
  localparam int UW      = $clog2(MAX_T + 1);

  logic [UW-1:0] us;
  logic [UW-1:0] us_nx;
  logic [UW-1:0] low_len;
  logic [UW-1:0] tot_len;
  logic [UW-1:0] smp_at;
  logic          smp_en;
  logic          at_smp;
  logic          at_end;

  always_comb begin
    low_len = UW'(T_W1_LOW);
    tot_len = UW'(T_SLOT);
    smp_at  = UW'(T_RD_SMP);
    smp_en  = 1'b0;
    unique case (op)
      OP_RST: begin
        low_len = UW'(T_RST_LOW);
        tot_len = UW'(RST_TOT);
        smp_at  = UW'(T_RST_LOW + T_PRES);
        smp_en  = 1'b1;
      end
      OP_WR0: begin
        low_len = UW'(T_W0_LOW);
      end
      OP_WR1: begin
        smp_en  = 1'b1;
      end
      default: ;
    endcase
    us_nx  = us + 1'b1;
    at_smp = tick && smp_en && (us_nx == smp_at);
    at_end = tick && (us_nx == tot_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op      <= OP_IDLE;
      us      <= '0;
      oe      <= 1'b0;
      done    <= 1'b0;
      no_pres <= 1'b0;
      rd_bit  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (op == OP_IDLE) begin
        if (start_vld && start_op != OP_IDLE) begin
          op <= start_op;
          us <= '0;
          oe <= 1'b1;
          if (start_op == OP_RST) no_pres <= 1'b1;
        end
      end else if (tick) begin
        us <= us_nx;
        if (us_nx == low_len) oe <= 1'b0;
        if (at_smp) begin
          if (op == OP_RST && !line_s) no_pres <= 1'b0;
          if (op == OP_WR1)            rd_bit  <= line_s;
        end
        if (at_end) begin
          op   <= OP_IDLE;
          done <= 1'b1;
          oe   <= 1'b0;
        end
      end
    end
  end

  p_oe_when_busy_r11: assert property (@(posedge clk) disable iff (rst)
    oe |-> op != OP_IDLE);

  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (op != OP_IDLE) |-> us < tot_len);

  p_rd_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WR0 || op == OP_RST) |=> $stable(rd_bit));

  p_pres_set_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_IDLE && start_vld && start_op == OP_RST) |=> no_pres);

  p_op_held_r8: assert property (@(posedge clk) disable iff (rst)
    (op != OP_IDLE && !done) |=> (op == $past(op)) || done);

endmodule

// File: rtl/ow_bus_master.sv
module ow_bus_master
  import ow_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int MIN_DIV   = 10,
  parameter int SYNC_FF   = 2,
  parameter int T_RST_LOW = 480,
  parameter int T_RST_REC = 480,
  parameter int T_PRES    = 70,
  parameter int T_W0_LOW  = 100,
  parameter int T_W1_LOW  = 5,
  parameter int T_RD_SMP  = 15,
  parameter int T_SLOT    = 117
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cmd_reset,
  input  logic             cmd_wr0,
  input  logic             cmd_wr1,
  output logic             busy,
  output logic             done,
  output logic             ctl_reset,
  output logic             ctl_wr0,
  output logic             ctl_wr1,
  output logic             no_presence,
  output logic             rd_bit,
  output logic             line_oe,
  input  logic             line_in
);
  op_e  op;
  op_e  req_op;
  logic accept;
  logic tick;
  logic line_s;

  always_comb begin
    if (cmd_reset)    req_op = OP_RST;
    else if (cmd_wr0) req_op = OP_WR0;
    else if (cmd_wr1) req_op = OP_WR1;
    else              req_op = OP_IDLE;
    busy      = (op != OP_IDLE);
    accept    = !busy && (req_op != OP_IDLE);
    ctl_reset = (op == OP_RST);
    ctl_wr0   = (op == OP_WR0);
    ctl_wr1   = (op == OP_WR1);
  end

  ow_tick_gen #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) i_tick (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .run    (busy),
    .div_in (clk_div),
    .tick   (tick)
  );

  ow_sync #(.STAGES(SYNC_FF), .IDLE_LV(1'b1)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_in),
    .q   (line_s)
  );

  ow_slot_seq #(
    .T_RST_LOW (T_RST_LOW),
    .T_RST_REC (T_RST_REC),
    .T_PRES    (T_PRES),
    .T_W0_LOW  (T_W0_LOW),
    .T_W1_LOW  (T_W1_LOW),
    .T_RD_SMP  (T_RD_SMP),
    .T_SLOT    (T_SLOT)
  ) i_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .start_vld (accept),
    .start_op  (req_op),
    .line_s    (line_s),
    .op        (op),
    .oe        (line_oe),
    .done      (done),
    .no_pres   (no_presence),
    .rd_bit    (rd_bit)
  );

  p_one_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_reset, ctl_wr0, ctl_wr1}));

  p_busy_ends_done_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> busy || done);

  p_prio_reset_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_reset) |=> ctl_reset);

endmodule

// File: tb/test_ow_bus_master.sv
module test_ow_bus_master;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] clk_div = 8'd12;
  logic          cmd_reset = 1'b0, cmd_wr0 = 1'b0, cmd_wr1 = 1'b0;
  logic          busy, done, ctl_reset, ctl_wr0, ctl_wr1;
  logic          no_presence, rd_bit, line_oe;
  logic          slave_pull = 1'b0;
  logic          line_in;
  int            slave_mode = 0;
  int            n_checks = 0;
  int            n_errors = 0;
  int            cur_div = 12;

  always #4 clk = ~clk;
  assign line_in = !(line_oe || slave_pull);

  ow_bus_master #(.DIV_W(DW)) i_ow_bus_master (
    .clk(clk), .rst(rst), .clk_div(clk_div),
    .cmd_reset(cmd_reset), .cmd_wr0(cmd_wr0), .cmd_wr1(cmd_wr1),
    .busy(busy), .done(done), .ctl_reset(ctl_reset), .ctl_wr0(ctl_wr0),
    .ctl_wr1(ctl_wr1), .no_presence(no_presence), .rd_bit(rd_bit),
    .line_oe(line_oe), .line_in(line_in)
  );

  // slave model: mode 1 answers a reset, mode 2 holds the line low in a slot
  initial forever begin
    @(posedge line_oe);
    if (slave_mode == 2) begin
      @(negedge clk); slave_pull = 1'b1;
      repeat (40 * cur_div) @(negedge clk);
      slave_pull = 1'b0;
    end else if (slave_mode == 1) begin
      @(negedge line_oe);
      repeat (30 * cur_div) @(negedge clk);
      slave_pull = 1'b1;
      repeat (120 * cur_div) @(negedge clk);
      slave_pull = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mask = {reset, wr0, wr1}; inj 1 = reset strobe mid-slot, 2 = divider change
  task automatic run_cmd(input logic [2:0] mask, input int inj_at, input int inj,
                         output int n_busy, output int n_oe, output int n_done,
                         output logic [2:0] bits);
    @(negedge clk);
    {cmd_reset, cmd_wr0, cmd_wr1} = mask;
    @(negedge clk);
    {cmd_reset, cmd_wr0, cmd_wr1} = 3'b000;
    bits = {ctl_reset, ctl_wr0, ctl_wr1};
    n_busy = 0; n_oe = 0; n_done = 0;
    while (!done && n_busy < 150000) begin
      if (busy) n_busy++;
      if (line_oe) n_oe++;
      if (n_busy == inj_at && inj == 1) cmd_reset = 1'b1;
      else cmd_reset = 1'b0;
      if (n_busy == inj_at && inj == 2) clk_div = 8'd20;
      @(negedge clk);
    end
    cmd_reset = 1'b0;
    if (done) n_done = 1;
    @(negedge clk);
    if (done) n_done++;
  endtask

  task automatic t_reset_state;
    chk("R1 line_oe", line_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 bits", {ctl_reset, ctl_wr0, ctl_wr1}, 0);
    chk("R1 no_presence", no_presence, 0);
    chk("R1 rd_bit", rd_bit, 0);
  endtask

  task automatic t_bus_reset(input int mode, input int exp_np);
    int b, o, d; logic [2:0] bits;
    slave_mode = mode;
    run_cmd(3'b100, -1, 0, b, o, d, bits);
    chk("R8 reset cmd bit", bits, 3'b100);
    chk("R3 reset low", o, 480 * cur_div);
    chk("R3 reset total", b, 960 * cur_div);
    chk("R3 done one clock", d, 1);
    chk("R8 bit cleared", {ctl_reset, ctl_wr0, ctl_wr1}, 0);
    chk("R4 no_presence", no_presence, exp_np);
    slave_mode = 0;
  endtask

  task automatic t_write0;
    int b, o, d; logic [2:0] bits;
    run_cmd(3'b010, -1, 0, b, o, d, bits);
    chk("R5 wr0 bit", bits, 3'b010);
    chk("R5 wr0 low", o, 100 * cur_div);
    chk("R5 wr0 slot", b, 117 * cur_div);
    chk("R11 released after", line_oe, 0);
  endtask

  task automatic t_read(input int mode, input int exp_rd);
    int b, o, d; logic [2:0] bits;
    slave_mode = mode;
    run_cmd(3'b001, -1, 0, b, o, d, bits);
    chk("R6 wr1 bit", bits, 3'b001);
    chk("R6 wr1 low", o, 5 * cur_div);
    chk("R6 wr1 slot", b, 117 * cur_div);
    chk("R6 rd_bit", rd_bit, exp_rd);
    slave_mode = 0;
    repeat (60 * cur_div) @(negedge clk);
  endtask

  task automatic t_busy_ignore;
    int b, o, d; logic [2:0] bits;
    logic np0;
    np0 = no_presence;
    run_cmd(3'b010, 50 * cur_div, 1, b, o, d, bits);
    chk("R8 wr0 low kept", o, 100 * cur_div);
    chk("R8 wr0 slot kept", b, 117 * cur_div);
    chk("R8 no_presence untouched", no_presence, np0);
    chk("R8 idle after", busy, 0);
  endtask

  task automatic t_priority;
    int b, o, d; logic [2:0] bits;
    run_cmd(3'b111, -1, 0, b, o, d, bits);
    chk("R9 reset wins", bits, 3'b100);
    chk("R9 reset low", o, 480 * cur_div);
    run_cmd(3'b011, -1, 0, b, o, d, bits);
    chk("R9 wr0 over wr1", bits, 3'b010);
    chk("R9 wr0 low", o, 100 * cur_div);
  endtask

  task automatic t_div_change;
    int b, o, d; logic [2:0] bits;
    run_cmd(3'b010, 20 * cur_div, 2, b, o, d, bits);
    chk("R10 low with old divider", o, 100 * 12);
    chk("R10 slot with old divider", b, 117 * 12);
    clk_div = 8'd12;
  endtask

  task automatic t_div_floor(input int dv);
    int b, o, d; logic [2:0] bits;
    clk_div = DW'(dv);
    cur_div = 10;
    run_cmd(3'b001, -1, 0, b, o, d, bits);
    chk("R2 floored low", o, 5 * 10);
    chk("R2 floored slot", b, 117 * 10);
    clk_div = 8'd12;
    cur_div = 12;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_bus_reset(1, 0);            // R4 device answers
    t_read(0, 1);                 // R6 line high -> 1
    t_write0();                   // R5
    chk("R7 rd kept over wr0", rd_bit, 1);
    t_bus_reset(0, 1);            // R4 no device
    chk("R7 rd kept over reset", rd_bit, 1);
    t_read(2, 0);                 // R6 slave holds low -> 0
    t_busy_ignore();              // R8
    t_priority();                 // R9
    t_div_change();               // R10
    t_div_floor(4);               // R2
    t_div_floor(0);               // R2
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule